// File: doc/BRIEF.md
# Single-Head Signal Sequencer with Pedestrian Phase

This block drives one vehicle signal head and one pedestrian crossing lamp pair. The vehicle head steps through red, then red and amber together, then green, then amber alone. After one full vehicle pass, a pedestrian phase follows. The walk lamp is first lit steadily, then it blinks, and then the cycle starts again at red. The vehicle head shows steady red for the whole pedestrian phase.

The clock runs at one cycle per second, so each clock edge is one tick of the timing. A synchronous, active-high reset restarts the sequence at the first tick of the red phase. All phase timing is held in one down-counter. The counter is reloaded with the length of the next phase each time the phase changes. The current phase number is brought out so that the phase order and the length of each phase can be checked from outside. Each phase length is a parameter.

Top module: `sig_head_seq`

## Requirements
- R1: In the first tick after reset, and in every tick while reset is held, `phase_o` is 0, `red_o` and `dontwalk_o` are 1, and `amb_o`, `grn_o` and `walk_o` are 0.
- R2: `phase_o` follows the order 0 (red), 1 (red with amber), 2 (green), 3 (amber), 4 (steady walk), 5 (blinking walk), and then returns to 0.
- R3: With the default parameters, the phases last 6, 1, 4, 2, 4 and 4 ticks, in phase order 0 to 5, for a full cycle of 21 ticks.
- R4: The vehicle lamps are red only in phase 0, red and amber in phase 1, green only in phase 2, and amber only in phase 3. Green is never lit together with red or amber.
- R5: In phases 4 and 5, red is lit and amber and green are off.
- R6: In phase 4, walk is lit steadily and don't-walk is off.
- R7: In phase 5, walk is lit in ticks 0 and 2 of the phase and dark in ticks 1 and 3, so it blinks one tick on and one tick off. Don't-walk stays off for the whole phase.
- R8: In phases 0 to 3, walk is off and don't-walk is on. Don't-walk comes back on in the first tick after the blinking ends.
- R9: A reset applied in the middle of a cycle restarts the sequence, and the red phase that follows lasts its full length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | One-second tick clock |
| rst | input | 1 | Synchronous active-high reset |
| phase_o | output | 3 | Current phase number (0 to 5) |
| red_o | output | 1 | Red vehicle lamp |
| amb_o | output | 1 | Amber vehicle lamp |
| grn_o | output | 1 | Green vehicle lamp |
| walk_o | output | 1 | Pedestrian walk lamp |
| dontwalk_o | output | 1 | Pedestrian don't-walk lamp |

## Verification
The situation that is hardest to reach from the ports is the handover from the last blinking-walk tick back to red. That handover occurs only after every earlier phase has run to its end. The stimulus therefore runs two full cycles without a break and checks every tick against a table of phase lengths and lamp patterns. This covers the wrap and shows that the second pass matches the first. A reset applied in the middle of green then checks that the red phase restarts with its full length, rather than being cut short by a stale count.

// File: rtl/sig_head_pkg.sv
package sig_head_pkg;

    typedef enum logic [2:0] {
        PH_RED    = 3'd0,
        PH_REDAMB = 3'd1,
        PH_GREEN  = 3'd2,
        PH_AMBER  = 3'd3,
        PH_WALK   = 3'd4,
        PH_FLASH  = 3'd5
    } phase_e;

    typedef struct packed {
        logic red;
        logic amb;
        logic grn;
        logic walk;
        logic dontwalk;
    } lamps_t;

    function automatic phase_e next_phase(phase_e p);
        case (p)
            PH_RED:    return PH_REDAMB;
            PH_REDAMB: return PH_GREEN;
            PH_GREEN:  return PH_AMBER;
            PH_AMBER:  return PH_WALK;
            PH_WALK:   return PH_FLASH;
            default:   return PH_RED;
        endcase
    endfunction

    function automatic int unsigned max_of2(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sig_phase_timer.sv
module sig_phase_timer
    import sig_head_pkg::*;
#(
    parameter int unsigned RED_T    = 6,
    parameter int unsigned REDAMB_T = 1,
    parameter int unsigned GREEN_T  = 4,
    parameter int unsigned AMBER_T  = 2,
    parameter int unsigned WALK_T   = 4,
    parameter int unsigned FLASH_T  = 4,
    parameter int unsigned CW       = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  phase_e        phase,
    output logic [CW-1:0] cnt,
    output logic          expire
);

    function automatic int unsigned phase_len(phase_e p);
        case (p)
            PH_RED:    return RED_T;
            PH_REDAMB: return REDAMB_T;
            PH_GREEN:  return GREEN_T;
            PH_AMBER:  return AMBER_T;
            PH_WALK:   return WALK_T;
            PH_FLASH:  return FLASH_T;
            default:   return RED_T;
        endcase
    endfunction

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] reload;

    always_comb begin
        reload = CW'(phase_len(next_phase(phase)) - 1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= CW'(RED_T - 1);
        end else if (cnt_q == '0) begin
            cnt_q <= reload;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign cnt    = cnt_q;
    assign expire = (cnt_q == '0);

endmodule

// File: rtl/sig_phase_reg.sv
module sig_phase_reg
    import sig_head_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   expire,
    output phase_e phase
);

    phase_e phase_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_RED;
        end else if (expire) begin
            phase_q <= next_phase(phase_q);
        end
    end

    assign phase = phase_q;

endmodule

// File: rtl/sig_lamp_decode.sv
module sig_lamp_decode
    import sig_head_pkg::*;
#(
    parameter int unsigned FLASH_T = 4,
    parameter int unsigned CW      = 3
) (
    input  phase_e        phase,
    input  logic [CW-1:0] cnt,
    output lamps_t        lamps
);

    localparam logic [CW-1:0] FLASH_LAST = CW'(FLASH_T - 1);

    logic blink_on;

    // Ticks elapsed = FLASH_LAST - cnt; lit when that is even.
    assign blink_on = (cnt[0] == FLASH_LAST[0]);

    always_comb begin
        lamps = '0;
        case (phase)
            PH_RED: begin
                lamps.red      = 1'b1;
                lamps.dontwalk = 1'b1;
            end
            PH_REDAMB: begin
                lamps.red      = 1'b1;
                lamps.amb      = 1'b1;
                lamps.dontwalk = 1'b1;
            end
            PH_GREEN: begin
                lamps.grn      = 1'b1;
                lamps.dontwalk = 1'b1;
            end
            PH_AMBER: begin
                lamps.amb      = 1'b1;
                lamps.dontwalk = 1'b1;
            end
            PH_WALK: begin
                lamps.red  = 1'b1;
                lamps.walk = 1'b1;
            end
            PH_FLASH: begin
                lamps.red  = 1'b1;
                lamps.walk = blink_on;
            end
            default: begin
                lamps.red      = 1'b1;
                lamps.dontwalk = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/sig_head_seq.sv
module sig_head_seq
    import sig_head_pkg::*;
#(
    parameter int unsigned RED_T    = 6,
    parameter int unsigned REDAMB_T = 1,
    parameter int unsigned GREEN_T  = 4,
    parameter int unsigned AMBER_T  = 2,
    parameter int unsigned WALK_T   = 4,
    parameter int unsigned FLASH_T  = 4
) (
    input  logic       clk,
    input  logic       rst,
    output logic [2:0] phase_o,
    output logic       red_o,
    output logic       amb_o,
    output logic       grn_o,
    output logic       walk_o,
    output logic       dontwalk_o
);

    localparam int unsigned MAXT = max_of2(max_of2(max_of2(RED_T, REDAMB_T), max_of2(GREEN_T, AMBER_T)),
                                           max_of2(max_of2(WALK_T, FLASH_T), 2));
    localparam int unsigned CW   = $clog2(MAXT + 1);

    phase_e        phase;
    logic [CW-1:0] cnt;
    logic          expire;
    lamps_t        lamps;

    sig_phase_timer #(
        .RED_T(RED_T), .REDAMB_T(REDAMB_T), .GREEN_T(GREEN_T),
        .AMBER_T(AMBER_T), .WALK_T(WALK_T), .FLASH_T(FLASH_T), .CW(CW)
    ) u_timer (
        .clk   (clk),
        .rst   (rst),
        .phase (phase),
        .cnt   (cnt),
        .expire(expire)
    );

    sig_phase_reg u_phase (
        .clk   (clk),
        .rst   (rst),
        .expire(expire),
        .phase (phase)
    );

    sig_lamp_decode #(
        .FLASH_T(FLASH_T), .CW(CW)
    ) u_decode (
        .phase(phase),
        .cnt  (cnt),
        .lamps(lamps)
    );

    assign phase_o    = phase;
    assign red_o      = lamps.red;
    assign amb_o      = lamps.amb;
    assign grn_o      = lamps.grn;
    assign walk_o     = lamps.walk;
    assign dontwalk_o = lamps.dontwalk;

endmodule

// File: rtl/sig_head_seq_chk.sv
module sig_head_seq_chk #(
    parameter int unsigned RED_T    = 6,
    parameter int unsigned REDAMB_T = 1,
    parameter int unsigned GREEN_T  = 4,
    parameter int unsigned AMBER_T  = 2,
    parameter int unsigned WALK_T   = 4,
    parameter int unsigned FLASH_T  = 4
) (
    input logic       clk,
    input logic       rst,
    input logic [2:0] phase_o,
    input logic       red_o,
    input logic       amb_o,
    input logic       grn_o,
    input logic       walk_o,
    input logic       dontwalk_o
);

    localparam int unsigned RW = 8;

    function automatic int unsigned plen(logic [2:0] p);
        case (p)
            3'd0:    return RED_T;
            3'd1:    return REDAMB_T;
            3'd2:    return GREEN_T;
            3'd3:    return AMBER_T;
            3'd4:    return WALK_T;
            3'd5:    return FLASH_T;
            default: return RED_T;
        endcase
    endfunction

    function automatic logic [2:0] pnext(logic [2:0] p);
        return (p >= 3'd5) ? 3'd0 : p + 3'd1;
    endfunction

    logic [2:0]    prev_ph;
    logic [RW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_ph <= 3'd0;
            run_q   <= '0;
        end else begin
            prev_ph <= phase_o;
            run_q   <= (phase_o != prev_ph) ? RW'(1) : run_q + 1'b1;
        end
    end

    // R2
    a_r2_order: assert property (@(posedge clk) disable iff (rst)
        (phase_o != prev_ph) |-> (phase_o == pnext(prev_ph)));

    // R3
    a_r3_full_length: assert property (@(posedge clk) disable iff (rst)
        (phase_o != prev_ph) |-> (run_q == RW'(plen(prev_ph))));

    a_r3_no_overrun: assert property (@(posedge clk) disable iff (rst)
        (phase_o == prev_ph) |-> (run_q < RW'(plen(phase_o))));

    // R4
    a_r4_green_alone: assert property (@(posedge clk) disable iff (rst)
        grn_o |-> (!red_o && !amb_o));

    // R5
    a_r5_red_in_ped: assert property (@(posedge clk) disable iff (rst)
        (phase_o >= 3'd4) |-> (red_o && !amb_o && !grn_o));

    // R6
    a_r6_steady_walk: assert property (@(posedge clk) disable iff (rst)
        (phase_o == 3'd4) |-> (walk_o && !dontwalk_o));

    // R7
    a_r7_blink_start: assert property (@(posedge clk) disable iff (rst)
        (phase_o == 3'd5 && prev_ph == 3'd4) |-> walk_o);

    a_r7_blink_toggle: assert property (@(posedge clk) disable iff (rst)
        (phase_o == 3'd5 && prev_ph == 3'd5) |-> (walk_o != $past(walk_o)));

    // R8
    a_r8_dontwalk: assert property (@(posedge clk) disable iff (rst)
        (phase_o < 3'd4) |-> (dontwalk_o && !walk_o));

endmodule

bind sig_head_seq sig_head_seq_chk #(
    .RED_T(RED_T), .REDAMB_T(REDAMB_T), .GREEN_T(GREEN_T),
    .AMBER_T(AMBER_T), .WALK_T(WALK_T), .FLASH_T(FLASH_T)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .phase_o   (phase_o),
    .red_o     (red_o),
    .amb_o     (amb_o),
    .grn_o     (grn_o),
    .walk_o    (walk_o),
    .dontwalk_o(dontwalk_o)
);

// File: tb/sig_head_seq_bench.sv
module sig_head_seq_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] phase_o;
    logic       red_o, amb_o, grn_o, walk_o, dontwalk_o;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    sig_head_seq u_sig_head_seq (
        .clk       (clk),
        .rst       (rst),
        .phase_o   (phase_o),
        .red_o     (red_o),
        .amb_o     (amb_o),
        .grn_o     (grn_o),
        .walk_o    (walk_o),
        .dontwalk_o(dontwalk_o)
    );

    // [11:9] phase, [8:5] ticks, [4] red, [3] amber, [2] green, [1:0] walk mode (0 none, 1 steady, 2 blink)
    localparam logic [11:0] VEC [6] = '{
        {3'd0, 4'd6, 3'b100, 2'd0},
        {3'd1, 4'd1, 3'b110, 2'd0},
        {3'd2, 4'd4, 3'b001, 2'd0},
        {3'd3, 4'd2, 3'b010, 2'd0},
        {3'd4, 4'd4, 3'b100, 2'd1},
        {3'd5, 4'd4, 3'b100, 2'd2}
    };

    task automatic check(input string tag, input logic [2:0] eph, input logic er,
                         input logic ea, input logic eg, input logic ew, input logic ed);
        logic [7:0] act, exp;
        act = {phase_o, red_o, amb_o, grn_o, walk_o, dontwalk_o};
        exp = {eph, er, ea, eg, ew, ed};
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got ph=%0d r%b a%b g%b w%b d%b, expected ph=%0d r%b a%b g%b w%b d%b",
                     tag, act[7:5], act[4], act[3], act[2], act[1], act[0],
                     exp[7:5], exp[4], exp[3], exp[2], exp[1], exp[0]);
        end
    endtask

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R1 reset state", 3'd0, 1, 0, 0, 0, 1);
        rst = 1'b0;

        // Two full cycles, every tick checked (R2 R3 R4 R5 R6 R7 R8)
        for (int cyc = 0; cyc < 2; cyc++) begin
            for (int v = 0; v < 6; v++) begin
                for (int t = 0; t < int'(VEC[v][8:5]); t++) begin
                    logic ew, ed;
                    ew = (VEC[v][1:0] == 2'd1) || (VEC[v][1:0] == 2'd2 && t % 2 == 0);
                    ed = (VEC[v][1:0] == 2'd0);
                    check(VEC[v][1:0] == 2'd2 ? "R7 blink" :
                          VEC[v][1:0] == 2'd1 ? "R6 steady walk" : "R2/R3/R4/R8 vehicle",
                          VEC[v][11:9], VEC[v][4], VEC[v][3], VEC[v][2], ew, ed);
                    @(negedge clk);
                end
            end
        end
        // Back at red tick 0 after the wrap
        check("R8 dont-walk after blink", 3'd0, 1, 0, 0, 0, 1);

        // Move into green tick 1, then reset mid-cycle (R9)
        repeat (8) @(negedge clk);
        check("R4 green before reset", 3'd2, 0, 0, 1, 0, 1);
        rst = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R1 reset held", 3'd0, 1, 0, 0, 0, 1);
        end
        rst = 1'b0;
        repeat (5) @(negedge clk);
        check("R9 red full length tick5", 3'd0, 1, 0, 0, 0, 1);
        @(negedge clk);
        check("R9 red ends after six", 3'd1, 1, 1, 0, 0, 1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_fail++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

endmodule